// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single-byte transfer requests from an internal core into cycles on an external bus whose low lines carry the address first and the data afterwards. A cycle can be a memory read, a memory write, an I/O read, an I/O write, an instruction fetch, an interrupt acknowledge or a halt. Each cycle runs through the clock states T1, T2 and T3, then any number of wait states, then T4. The block produces the address latch strobe, the read, write and acknowledge strobes, the data direction and data enable controls, and an encoded cycle status. It also drives the upper address lines, which carry address bits in T1 and segment status after T1.

The core gives a one-clock request pulse while the sequencer is idle. The request carries the kind of cycle, a 20-bit address, a segment tag and, for a write, the byte to send. Pulses that arrive while a cycle is running are dropped. The sequencer adds wait states for as long as the registered ready input stays low. Read data comes back on `rd_data`, and a one-clock `done` pulse in T4 marks the end of every cycle. After a halt cycle the sequencer stays idle until reset.

Top module: `mbus_seq`

## Requirements
- R1: While reset is high, and in the first clock after it falls, `stat` is 3'b111, `ale`, `done` and `ad_oe` are 0, and `rd_n`, `wr_n`, `inta_n`, `den_n` and `dt_r` are 1.
- R2: An accepted request starts T1 on the next clock. A cycle lasts exactly 4 + N clocks, where N is the number of wait states. `ale` is high in T1 only.
- R3: `req_kind` and `stat` use the same codes: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 fetch, 101 memory read, 110 memory write, 111 passive. `stat` holds the cycle's code from T1 up to, but not including, the state just before T4. It is 111 in that state, in T4 and while idle.
- R4: In T1, `ahi` carries address bits 19:16, forced to zero for I/O cycles (codes 001 and 010). From T2 to T4, `ahi` carries {2'b00, segment}. The segment codes are 00 extra, 01 stack, 10 code or none, 11 data. `ahi` is 0 while idle.
- R5: In T1, `ad_out` carries address bits 7:0 with `ad_oe` high. For writes, `ad_out` carries the write byte with `ad_oe` high from T2 to T4. For reads, `ad_oe` is low from T2 on. `a_mid` carries address bits 15:8 for the whole cycle. Undriven outputs are 0.
- R6: A wait state follows T3, and then each wait state, for as long as `rdy` registered at the start of that state is low. T4 follows once it is high.
- R7: `rd_n` (codes 001, 100, 101), `wr_n` (codes 010, 110) and `inta_n` (code 000) are low from T2 through the last wait state and high in T1 and T4. At most one of them is low at a time.
- R8: `dt_r` is 0 from T1 to T4 of read and acknowledge cycles and 1 otherwise. `den_n` is low from T2 to T4 of every cycle except halt.
- R9: For reads, `ad_in` is captured at the clock edge that enters T4 and shown on `rd_data` from T4. `done` is a one-clock pulse in T4.
- R10: A halt cycle (code 011) asserts no strobe, ignores `rdy`, and takes exactly 4 clocks. After it, all requests are ignored until reset.
- R11: A request is ignored if it arrives while a cycle is running or if its kind is 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-clock request pulse from the core |
| req_kind | input | 3 | Cycle kind, coded as `stat` |
| req_addr | input | 20 | Byte address |
| req_seg | input | 2 | Segment tag |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-clock end-of-cycle pulse in T4 |
| rd_data | output | 8 | Captured read byte |
| rdy | input | 1 | External ready, registered each clock |
| ad_in | input | 8 | Low address/data lines, incoming |
| ad_out | output | 8 | Low address/data lines, outgoing |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| a_mid | output | 8 | Address bits 15:8 |
| ahi | output | 4 | Address bits 19:16 in T1, segment status afterwards |
| stat | output | 3 | Encoded cycle status |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| dt_r | output | 1 | Data direction: 1 transmit, 0 receive |
| den_n | output | 1 | Data enable, active low |

## Verification
The bench drives `ad_in` with the true byte only in the state just before T4. A design that captured one clock early or late would return the complement of the byte. It varies the number of wait states from zero to five and checks the exact clock in which `stat` goes passive and `done` fires, so an off-by-one in the ready handling would show up. It sends requests in the middle of a cycle and after a halt, so a sequencer that accepted them would raise `ale` where none is expected. It also sends an I/O cycle with a nonzero upper address, which a design that forgot to zero the upper lines would put on the bus.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        CYC_INTA  = 3'b000,
        CYC_IORD  = 3'b001,
        CYC_IOWR  = 3'b010,
        CYC_HALT  = 3'b011,
        CYC_FETCH = 3'b100,
        CYC_MEMRD = 3'b101,
        CYC_MEMWR = 3'b110,
        CYC_NONE  = 3'b111
    } cyc_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_TW,
        PH_T4,
        PH_STOP
    } phase_e;

    function automatic logic is_read(cyc_e k);
        return (k == CYC_INTA) || (k == CYC_IORD) || (k == CYC_FETCH) || (k == CYC_MEMRD);
    endfunction

    function automatic logic is_write(cyc_e k);
        return (k == CYC_IOWR) || (k == CYC_MEMWR);
    endfunction

    function automatic logic is_io(cyc_e k);
        return (k == CYC_IORD) || (k == CYC_IOWR);
    endfunction

endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_seg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rdy,
    input  logic [DATA_W-1:0] ad_in,
    output phase_e            phase,
    output cyc_e              kind_q,
    output logic [1:0]        seg_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              pre_t4,
    output logic [DATA_W-1:0] rd_data
);

    logic   rdy_q;
    logic   accept;
    phase_e nxt;

    assign accept = (phase == PH_IDLE) && req_valid && (cyc_e'(req_kind) != CYC_NONE);

    // The state that hands over to T4: T3 when no wait is due, else the last wait.
    assign pre_t4 = ((phase == PH_T3) && ((kind_q == CYC_HALT) || rdy_q)) ||
                    ((phase == PH_TW) && rdy_q);

    always_comb begin
        unique case (phase)
            PH_IDLE: nxt = accept ? PH_T1 : PH_IDLE;
            PH_T1:   nxt = PH_T2;
            PH_T2:   nxt = PH_T3;
            PH_T3,
            PH_TW:   nxt = pre_t4 ? PH_T4 : PH_TW;
            PH_T4:   nxt = (kind_q == CYC_HALT) ? PH_STOP : PH_IDLE;
            PH_STOP: nxt = PH_STOP;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            rdy_q   <= 1'b0;
            kind_q  <= CYC_NONE;
            seg_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_data <= '0;
        end else begin
            phase <= nxt;
            rdy_q <= rdy;
            if (accept) begin
                kind_q  <= cyc_e'(req_kind);
                seg_q   <= req_seg;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (pre_t4 && is_read(kind_q)) begin
                rd_data <= ad_in;
            end
        end
    end

endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - 16,
    localparam int MID_W = 16 - DATA_W
) (
    input  phase_e            phase,
    input  cyc_e              kind_q,
    input  logic [1:0]        seg_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              pre_t4,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [MID_W-1:0]  a_mid,
    output logic [HI_W-1:0]   ahi,
    output logic [2:0]        stat,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              dt_r,
    output logic              den_n,
    output logic              done
);

    logic in_cyc, in_t1, data_ph, strobe_win, rd_k, wr_k;
    logic [HI_W-1:0] ext_stat;

    assign in_t1      = (phase == PH_T1);
    assign data_ph    = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW) || (phase == PH_T4);
    assign in_cyc     = in_t1 || data_ph;
    assign strobe_win = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
    assign rd_k       = is_read(kind_q);
    assign wr_k       = is_write(kind_q);
    assign ext_stat   = {{(HI_W-2){1'b0}}, seg_q};

    always_comb begin
        ale    = in_t1;
        done   = (phase == PH_T4);
        stat   = (in_cyc && (phase != PH_T4) && !pre_t4) ? kind_q : CYC_NONE;
        rd_n   = !(strobe_win && rd_k && (kind_q != CYC_INTA));
        inta_n = !(strobe_win && (kind_q == CYC_INTA));
        wr_n   = !(strobe_win && wr_k);
        dt_r   = !(in_cyc && rd_k);
        den_n  = !(data_ph && (kind_q != CYC_HALT));
        ad_oe  = in_t1 || (data_ph && wr_k);
        if (in_t1) begin
            ad_out = addr_q[DATA_W-1:0];
        end else if (data_ph && wr_k) begin
            ad_out = wdata_q;
        end else begin
            ad_out = '0;
        end
        a_mid = in_cyc ? addr_q[15:DATA_W] : '0;
        if (in_t1) begin
            ahi = is_io(kind_q) ? '0 : addr_q[ADDR_W-1:16];
        end else if (data_ph) begin
            ahi = ext_stat;
        end else begin
            ahi = '0;
        end
    end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - 16,
    localparam int MID_W = 16 - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_seg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rdy,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [MID_W-1:0]  a_mid,
    output logic [HI_W-1:0]   ahi,
    output logic [2:0]        stat,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              dt_r,
    output logic              den_n
);

    phase_e            phase;
    cyc_e              kind_q;
    logic [1:0]        seg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              pre_t4;

    mbus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_seg   (req_seg),
        .req_wdata (req_wdata),
        .rdy       (rdy),
        .ad_in     (ad_in),
        .phase     (phase),
        .kind_q    (kind_q),
        .seg_q     (seg_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .pre_t4    (pre_t4),
        .rd_data   (rd_data)
    );

    mbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .phase   (phase),
        .kind_q  (kind_q),
        .seg_q   (seg_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .pre_t4  (pre_t4),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .a_mid   (a_mid),
        .ahi     (ahi),
        .stat    (stat),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .inta_n  (inta_n),
        .dt_r    (dt_r),
        .den_n   (den_n),
        .done    (done)
    );

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk #(
    parameter int HI_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            inta_n,
    input logic            dt_r,
    input logic            den_n,
    input logic            ad_oe,
    input logic            done,
    input logic [2:0]      stat,
    input logic [HI_W-1:0] ahi
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat == 3'b111 && !ale && !done)); // R1
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale); // R2
    AST_ALE_ACTIVE_STAT: assert property (@(posedge clk) disable iff (rst)
        ale |-> (stat != 3'b111)); // R3
    AST_DONE_PASSIVE: assert property (@(posedge clk) disable iff (rst)
        done |-> (stat == 3'b111)); // R3
    AST_IO_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ale && (stat == 3'b001 || stat == 3'b010)) |-> (ahi == '0)); // R4
    AST_WR_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (ad_oe && dt_r)); // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({!rd_n, !wr_n, !inta_n}) <= 1); // R7
    AST_STROBE_OFF_T4: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_n && wr_n && inta_n)); // R7
    AST_STROBE_OFF_T1: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n && inta_n)); // R7
    AST_RD_RECEIVES: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !inta_n) |-> (!ad_oe && !dt_r)); // R8
    AST_DEN_COVERS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n || !inta_n) |-> !den_n); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

endmodule

bind mbus_seq mbus_seq_chk #(.HI_W(ADDR_W - 16)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .inta_n (inta_n),
    .dt_r   (dt_r),
    .den_n  (den_n),
    .ad_oe  (ad_oe),
    .done   (done),
    .stat   (stat),
    .ahi    (ahi)
);

// File: tb/mbus_seq_tb.sv
`timescale 1ns/1ps
module mbus_seq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [19:0] req_addr;
    logic [1:0]  req_seg;
    logic [7:0]  req_wdata;
    logic        done;
    logic [7:0]  rd_data;
    logic        rdy;
    logic [7:0]  ad_in;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  a_mid;
    logic [3:0]  ahi;
    logic [2:0]  stat;
    logic        ale, rd_n, wr_n, inta_n, dt_r, den_n;

    int  nchk = 0;
    int  nfail = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    mbus_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_seg(req_seg), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .rdy(rdy), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_mid(a_mid), .ahi(ahi), .stat(stat),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .dt_r(dt_r), .den_n(den_n)
    );

    // {kind, addr, seg, wdata, read byte, waits}
    localparam logic [44:0] VEC [8] = '{
        {3'b101, 20'hA5C3E, 2'b11, 8'h00, 8'h3C, 4'd0},
        {3'b110, 20'h1F00D, 2'b10, 8'h96, 8'h00, 4'd2},
        {3'b001, 20'hF1234, 2'b11, 8'h00, 8'h5A, 4'd1},
        {3'b010, 20'h7ABCD, 2'b00, 8'hC3, 8'h00, 4'd0},
        {3'b100, 20'h3FFF0, 2'b10, 8'h00, 8'hE1, 4'd3},
        {3'b000, 20'h00000, 2'b10, 8'h00, 8'h08, 4'd1},
        {3'b101, 20'hFFFFF, 2'b01, 8'h00, 8'h81, 4'd5},
        {3'b110, 20'h80001, 2'b01, 8'h7E, 8'h00, 4'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_quiet(input string req);
        check(req, {ale, done, ad_oe, rd_n, wr_n, inta_n, den_n, dt_r}, 32'b00011111);
        check(req, {29'd0, stat}, 32'h7);
    endtask

    task automatic run_cycle(input logic [2:0] kind, input logic [19:0] addr,
                             input logic [1:0] seg, input logic [7:0] wd,
                             input logic [7:0] rdin, input int waits,
                             input bit rdy_low, input bit poke);
        int  len = 4 + waits;
        bit  rd = (kind == 3'b000) || (kind == 3'b001) || (kind == 3'b100) || (kind == 3'b101);
        bit  wr = (kind == 3'b010) || (kind == 3'b110);
        bit  io = (kind == 3'b001) || (kind == 3'b010);
        bit  rds = (kind == 3'b001) || (kind == 3'b100) || (kind == 3'b101);
        bit  hlt = (kind == 3'b011);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_seg = seg; req_wdata = wd;
        rdy = rdy_low ? 1'b0 : (waits == 0);
        ad_in = ~rdin;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k <= len; k++) begin
            bit in_c = (k <= len - 1);
            bit win  = (k >= 1) && (k <= len - 2);
            bit oe   = (k == 0) || (wr && k >= 1 && in_c);
            logic [7:0] e_out = (k == 0) ? addr[7:0] : (oe ? wd : 8'h00);
            logic [3:0] e_hi  = (k == 0) ? (io ? 4'h0 : addr[19:16]) : (in_c ? {2'b00, seg} : 4'h0);
            logic [2:0] e_st  = (k <= len - 3) ? kind : 3'b111;
            check("R2 ale", {31'd0, ale}, {31'd0, (k == 0)});
            check("R3 stat", {29'd0, stat}, {29'd0, e_st});
            check("R4 ahi", {28'd0, ahi}, {28'd0, e_hi});
            check("R5 ad_oe/ad_out", {23'd0, ad_oe, ad_out}, {23'd0, oe, e_out});
            check("R5 a_mid", {24'd0, a_mid}, {24'd0, in_c ? addr[15:8] : 8'h00});
            check(hlt ? "R10 strobes" : "R7 strobes", {29'd0, rd_n, wr_n, inta_n},
                  {29'd0, !(win && rds), !(win && wr), !(win && kind == 3'b000)});
            check("R8 dt_r/den_n", {30'd0, dt_r, den_n},
                  {30'd0, !(rd && in_c), !(k >= 1 && in_c && !hlt)});
            check("R6 R9 done", {31'd0, done}, {31'd0, (k == len - 1)});
            if (k == len - 1 && rd) check("R9 rd_data", {24'd0, rd_data}, {24'd0, rdin});
            if (k == len && poke) check("R11 busy request ignored", {31'd0, ale}, 32'd0);
            rdy   = rdy_low ? 1'b0 : (k + 1 >= 2 + waits);
            ad_in = (k + 1 == len - 1) ? rdin : ~rdin;
            if (poke && k == 1) begin
                req_valid = 1'b1; req_kind = 3'b101; req_addr = 20'h12345;
            end else if (poke && k == 2) begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 3'b111; req_addr = '0;
        req_seg = '0; req_wdata = '0; rdy = 1'b1; ad_in = '0;
        repeat (3) @(negedge clk);
        check_quiet("R1 during reset");
        check("R1 ad_out/ahi/a_mid", {12'd0, ad_out, ahi, a_mid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check_quiet("R1 after reset");

        // R11: passive kind is not a request
        req_valid = 1'b1; req_kind = 3'b111;
        @(negedge clk);
        req_valid = 1'b0;
        check_quiet("R11 passive kind");
        @(negedge clk);
        check_quiet("R11 passive kind");

        for (int i = 0; i < 8; i++) begin
            logic [44:0] v = VEC[i];
            run_cycle(v[44:42], v[41:22], v[21:20], v[19:12], v[11:4], int'(v[3:0]), 1'b0, i[0]);
        end

        // R10: halt ignores a low ready and then locks out requests
        run_cycle(3'b011, 20'h0BEEF, 2'b10, 8'h00, 8'h00, 0, 1'b1, 1'b0);
        rdy = 1'b1;
        req_valid = 1'b1; req_kind = 3'b101; req_addr = 20'h00042;
        @(negedge clk);
        req_valid = 1'b0;
        for (int j = 0; j < 5; j++) begin
            check_quiet("R10 halted");
            @(negedge clk);
        end

        rst = 1'b1;
        @(negedge clk);
        check_quiet("R1 reset after halt");
        rst = 1'b0;
        @(negedge clk);
        run_cycle(3'b101, 20'h2468A, 2'b01, 8'h00, 8'hA7, 1, 1'b0, 1'b0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule